// File: doc/BRIEF.md
# Two-Phase Transition-Signalled FIFO Pipeline Control

This block is a chain of pipeline stages that pass data tokens using two-phase (transition) handshakes, modelled in clocked logic. Every toggle of a request or acknowledge wire is one handshake event, whichever way the wire moves. The sender toggles the input request after placing a data word. The block toggles the input acknowledge once the first stage has captured that word. At the far end, the last stage toggles the output request to offer a word, and the receiver toggles the output acknowledge once it has taken the word.

Each stage keeps one phase bit and one data register. A rendezvous element (a C-element in event form) decides when the stage fires. It looks at three phases: the request phase from the stage before, the stage's own phase, and the acknowledge phase from the stage after. A stage fires when the upstream phase differs from its own and the downstream phase equals its own. When it fires, the stage copies the upstream data and flips its phase bit. That one flip serves as both the forward request and the backward acknowledge. Tokens ripple forward one stage per clock into free space, and the chain can hold up to DEPTH words.

Top module: `mp_fifo_chain`

## Requirements
- R1: After reset, in_ack, out_req and every stage phase are 0, and out_data is 0.
- R2: In an empty chain, a new input event (in_req differing from in_ack) is acknowledged by a toggle of in_ack one clock edge after in_req is sampled changed.
- R3: In an empty chain, out_req toggles exactly DEPTH clock edges after the new in_req is sampled, and carries the word that was presented.
- R4: Words leave in the order they entered, with no loss or duplication. While no word is outstanding, out_req equals out_ack.
- R5: With out_ack held, the chain accepts exactly DEPTH words. A further request stays unacknowledged (in_ack differs from in_req) until the receiver acknowledges.
- R6: Rising and falling transitions are both events: odd-numbered words arrive on a 0-to-1 toggle of out_req and even-numbered words on a 1-to-0 toggle.
- R7: While out_req differs from out_ack, out_data does not change.
- R8: While out_req differs from out_ack, out_req does not toggle again.
- R9: While in_req equals in_ack, in_ack does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Sender request phase; a toggle offers in_data |
| in_data | input | WIDTH | Sender data, held stable while the request is pending |
| in_ack | output | 1 | Acknowledge phase back to the sender |
| out_req | output | 1 | Request phase to the receiver; a toggle offers out_data |
| out_data | output | WIDTH | Data of the last stage |
| out_ack | input | 1 | Receiver acknowledge phase |

## Verification
A stage phase bit that flips wrongly shows up at the ports as an extra or missing output event. That appears as a duplicated or dropped word at the scoreboard within DEPTH cycles of the fault, or as an acknowledge arriving while the chain is full. A stale or wrongly chosen data register shows up as a word mismatch when that token reaches the output. A firing rule that ignores the downstream phase lets out_req or out_data move while the receiver has not yet acknowledged, and this is flagged on the very next cycle. Exact latency checks on an empty chain expose any extra or missing register along the path.

// File: rtl/mp_pkg.sv
package mp_pkg;
    localparam int DEF_DEPTH = 4;
    localparam int DEF_WIDTH = 8;

    // Event-form rendezvous: upstream holds a new event, downstream has
    // taken the previous one.
    function automatic logic phase_fire(input logic up_phase,
                                        input logic own_phase,
                                        input logic dn_phase);
        return (up_phase != own_phase) && (dn_phase == own_phase);
    endfunction
endpackage

// File: rtl/mp_celem.sv
module mp_celem (
    input  logic up_phase,
    input  logic own_phase,
    input  logic dn_phase,
    output logic fire
);
    always_comb begin
        fire = mp_pkg::phase_fire(up_phase, own_phase, dn_phase);
    end
endmodule

// File: rtl/mp_stage.sv
module mp_stage #(
    parameter int WIDTH = mp_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_phase,
    input  logic [WIDTH-1:0] up_data,
    input  logic             dn_phase,
    output logic             phase,
    output logic [WIDTH-1:0] data
);
    typedef struct packed {
        logic             ph;
        logic [WIDTH-1:0] dat;
    } stage_t;

    stage_t st_d, st_q;
    logic   fire;

    mp_celem celem_i (
        .up_phase (up_phase),
        .own_phase(st_q.ph),
        .dn_phase (dn_phase),
        .fire     (fire)
    );

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.ph  = ~st_q.ph;
            st_d.dat = up_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;
    assign data  = st_q.dat;
endmodule

// File: rtl/mp_fifo_chain.sv
module mp_fifo_chain #(
    parameter int DEPTH = mp_pkg::DEF_DEPTH,
    parameter int WIDTH = mp_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_req,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ack,
    output logic             out_req,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_ack
);
    localparam int LAST = DEPTH - 1;

    logic             phase_w [DEPTH];
    logic [WIDTH-1:0] data_w  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic             up_ph;
        logic [WIDTH-1:0] up_dat;
        logic             dn_ph;

        if (i == 0) begin : g_head
            assign up_ph  = in_req;
            assign up_dat = in_data;
        end else begin : g_mid_up
            assign up_ph  = phase_w[i-1];
            assign up_dat = data_w[i-1];
        end

        if (i == LAST) begin : g_tail
            assign dn_ph = out_ack;
        end else begin : g_mid_dn
            assign dn_ph = phase_w[i+1];
        end

        mp_stage #(.WIDTH(WIDTH)) stage_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .up_phase(up_ph),
            .up_data (up_dat),
            .dn_phase(dn_ph),
            .phase   (phase_w[i]),
            .data    (data_w[i])
        );
    end

    // One phase flip is both the stage's forward request and its backward acknowledge.
    assign in_ack   = phase_w[0];
    assign out_req  = phase_w[LAST];
    assign out_data = data_w[LAST];
endmodule

// File: rtl/mp_fifo_chain_chk.sv
module mp_fifo_chain_chk #(
    parameter int DEPTH = mp_pkg::DEF_DEPTH,
    parameter int WIDTH = mp_pkg::DEF_WIDTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_req,
    input logic             in_ack,
    input logic             out_req,
    input logic [WIDTH-1:0] out_data,
    input logic             out_ack
);
    localparam int CW = $clog2(DEPTH + 1) + 2;

    logic          prev_in_ack_q, prev_out_ack_q;
    logic [CW-1:0] cnt_q;
    int            occ;

    always_comb begin
        occ = int'(cnt_q) + ((in_ack != prev_in_ack_q) ? 1 : 0)
                          - ((out_ack != prev_out_ack_q) ? 1 : 0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_in_ack_q  <= 1'b0;
            prev_out_ack_q <= 1'b0;
            cnt_q          <= '0;
        end else begin
            prev_in_ack_q  <= in_ack;
            prev_out_ack_q <= out_ack;
            cnt_q          <= CW'(occ);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH); // R5
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == 0) |-> (out_req == out_ack)); // R4
    AST_OUT_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req != out_ack) |=> $stable(out_data)); // R7
    AST_OUT_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req != out_ack) |=> $stable(out_req)); // R8
    AST_IN_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req == in_ack) |=> $stable(in_ack)); // R9
endmodule

bind mp_fifo_chain mp_fifo_chain_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_req  (in_req),
    .in_ack  (in_ack),
    .out_req (out_req),
    .out_data(out_data),
    .out_ack (out_ack)
);

// File: tb/mp_fifo_chain_tb_top.sv
module mp_fifo_chain_tb_top;
    localparam int DEPTH = 4;
    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_req = 1'b0;
    logic [WIDTH-1:0] in_data = '0;
    logic             in_ack;
    logic             out_req;
    logic [WIDTH-1:0] out_data;
    logic             out_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    int rcv    = 0;
    int sent   = 0;
    bit rx_en   = 1'b0;
    bit rx_rand = 1'b0;
    logic [WIDTH-1:0] exp_q[$];

    always #10 clk = ~clk; // 50 MHz

    mp_fifo_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
        .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: wait for the previous event to be acknowledged, then toggle.
    task automatic send(input logic [WIDTH-1:0] v);
        @(negedge clk);
        while (in_req != in_ack) @(negedge clk);
        in_data = v;
        in_req  = ~in_req;
        exp_q.push_back(v);
        sent++;
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rx_en && (out_req != out_ack) &&
                (!rx_rand || ($urandom_range(3) != 0))) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 extra word", int'(out_data), 0);
                end else begin
                    logic [WIDTH-1:0] e;
                    e = exp_q.pop_front();
                    chk(out_data === e, "R4 order", int'(out_data), int'(e));
                end
                rcv++;
                out_ack = ~out_ack;
            end
        end
    end

    task automatic drain();
        int t = 0;
        while ((exp_q.size() != 0 || out_req != out_ack) && t < 2000) begin
            @(negedge clk);
            t++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(in_ack == 1'b0, "R1 in_ack", int'(in_ack), 0);
        chk(out_req == 1'b0, "R1 out_req", int'(out_req), 0);
        chk(out_data == '0, "R1 out_data", int'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3: latency through an empty chain, receiver paused
        begin
            int ack_cyc = 0;
            int out_cyc = 0;
            in_data = 8'hA5;
            in_req  = ~in_req;
            exp_q.push_back(8'hA5);
            sent++;
            for (int c = 1; c <= 3 * DEPTH; c++) begin
                @(negedge clk);
                if (ack_cyc == 0 && in_ack == in_req) ack_cyc = c;
                if (out_cyc == 0 && out_req != out_ack) out_cyc = c;
            end
            chk(ack_cyc == 1, "R2 ack latency", ack_cyc, 1);
            chk(out_cyc == DEPTH, "R3 out latency", out_cyc, DEPTH);
            chk(out_data == 8'hA5, "R3 out data", int'(out_data), 8'hA5);
            // R6: first word arrives on a rising out_req
            chk(out_req == 1'b1, "R6 rising event", int'(out_req), 1);
        end

        // R9: no request pending, in_ack stays put
        begin
            logic a0;
            bit moved = 1'b0;
            a0 = in_ack;
            repeat (6) begin
                @(negedge clk);
                if (in_ack != a0) moved = 1'b1;
            end
            chk(!moved, "R9 idle in_ack", int'(moved), 0);
        end

        // R6: second word arrives on a falling out_req
        rx_en = 1'b1;
        send(8'h3C);
        drain();
        chk(out_req == 1'b0, "R6 falling event", int'(out_req), 0);
        chk(rcv == 2, "R6 words received", rcv, 2);

        // R5 / R7 / R8: fill with receiver paused
        rx_en = 1'b0;
        for (int k = 0; k < DEPTH; k++) send(WIDTH'(8'h10 + k));
        repeat (3 * DEPTH) @(negedge clk);
        chk(in_ack == in_req, "R5 accepts DEPTH", int'(in_ack), int'(in_req));
        send(8'h77); // one beyond capacity
        begin
            logic             r0;
            logic [WIDTH-1:0] d0;
            bit moved = 1'b0;
            bit dmov  = 1'b0;
            r0 = out_req;
            d0 = out_data;
            repeat (4 * DEPTH) begin
                @(negedge clk);
                if (out_req != r0) moved = 1'b1;
                if (out_data != d0) dmov = 1'b1;
            end
            chk(in_ack != in_req, "R5 extra held", int'(in_ack), int'(~in_req));
            chk(!moved, "R8 out_req held", int'(moved), 0);
            chk(!dmov, "R7 out_data held", int'(dmov), 0);
            chk(d0 == 8'h10, "R4 head word", int'(d0), 8'h10);
        end
        rx_en = 1'b1;
        drain();
        chk(exp_q.size() == 0, "R4 drained after full", exp_q.size(), 0);
        chk(in_ack == in_req, "R5 extra accepted after ack", int'(in_ack), int'(in_req));

        // R4: random stream with random stalls on both sides
        rx_rand = 1'b1;
        for (int k = 0; k < 200; k++) begin
            repeat ($urandom_range(2)) @(negedge clk);
            send(WIDTH'($urandom));
        end
        drain();
        chk(exp_q.size() == 0, "R4 no loss", exp_q.size(), 0);
        chk(rcv == sent, "R4 count", rcv, sent);
        chk(out_req == out_ack, "R4 idle after stream", int'(out_req), int'(out_ack));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule